// File: doc/BRIEF.md
# Physical Register Occupancy Tracker

This block keeps, for a rename stage, the number of physical registers in use in each of several register files. File 0 is an aggregate file that is always present and counts every register taken by any file. Every destination is described by an owning file index and a cost, which is the number of physical registers it consumes. The rename stage presents a group of destinations on the query port. The block answers in the same cycle with one stall bit per file.

Once a group is renamed, its destinations are presented on the allocate port. When they retire, they are presented on the free port. Allocate and free may fall in the same cycle, and their net effect is applied in one step. A per-slot skip flag marks destinations that take no physical register: zero idioms, eliminated moves, and partial writes that are kept with their wider register and not renamed. The capacity of each file comes in on a configuration input. A capacity of zero means the file is unbounded.

Top module: `phys_reg_occupancy`

## Requirements
- R1: While reset is high, and in the first cycle after it, every used count reads zero. `used_o` holds file i at bits [i*CNT_W +: CNT_W].
- R2: A valid, non-skipped allocate slot owned by file k (k not 0) adds its cost to both file k and file 0 at the next clock edge. Slot s has its owner at bits [s*FIDX_W +: FIDX_W] and its cost at bits [s*COST_W +: COST_W].
- R3: A valid, non-skipped allocate slot with owner 0 adds its cost to file 0 only.
- R4: A valid, non-skipped free slot subtracts its cost from its owning file and from file 0. For owner 0, it subtracts from file 0 only.
- R5: An allocate or free slot that has its skip bit set, or its valid bit clear, changes no count.
- R6: When allocate and free happen in the same cycle, each count moves by the allocated total minus the freed total in one step. A count is never driven below zero.
- R7: For each file i, the requirement is the sum of the costs of the valid query slots that charge file i (every slot charges file 0). `q_stall[i]` is 1 when cap_i < used_i + requirement_i. `cap_i` is at bits [i*CNT_W +: CNT_W].
- R8: A file whose capacity is zero never sets its stall bit.
- R9: A requirement larger than the file's capacity is clamped to the capacity before the comparison.
- R10: A file whose requirement is zero never sets its stall bit, even when its used count is above its capacity.
- R11: `q_stall` is combinational. It follows the query inputs, the capacities and the present counts within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_i | input | NUM_FILES*CNT_W | Capacity of each file; 0 means unbounded |
| q_valid | input | SLOTS | Query slot valid |
| q_owner | input | SLOTS*FIDX_W | Query slot owning file |
| q_cost | input | SLOTS*COST_W | Query slot cost |
| q_stall | output | NUM_FILES | Per-file stall mask for the query group |
| a_valid | input | SLOTS | Allocate slot valid |
| a_skip | input | SLOTS | Allocate slot takes no register |
| a_owner | input | SLOTS*FIDX_W | Allocate slot owning file |
| a_cost | input | SLOTS*COST_W | Allocate slot cost |
| f_valid | input | SLOTS | Free slot valid |
| f_skip | input | SLOTS | Free slot returns no register |
| f_owner | input | SLOTS*FIDX_W | Free slot owning file |
| f_cost | input | SLOTS*COST_W | Free slot cost |
| used_o | output | NUM_FILES*CNT_W | Registered used count of each file |

## Verification
Allocation and release can land on the same clock edge, and can touch the same file. A directed step allocates and frees in file 1 together. Random cycles also mix both ports freely, with frees limited to registers that the reference counts show as outstanding. Each count after the edge is compared with the previous count plus the allocated total minus the freed total. A query is presented in the same cycles, so the stall mask is judged against the counts as they stood before that edge.

// File: rtl/occ_pkg.sv
package occ_pkg;
  // a destination always charges the aggregate file and its own file
  function automatic logic charges_file(input int file_idx, input int owner_idx);
    return (file_idx == 0) || (file_idx == owner_idx);
  endfunction
endpackage

// File: rtl/occ_demand.sv
module occ_demand #(
  parameter int NUM_FILES = 3,
  parameter int SLOTS     = 4,
  parameter int FIDX_W    = 2,
  parameter int COST_W    = 3,
  parameter int SUM_W     = 6
) (
  input  logic [SLOTS-1:0]           valid_i,
  input  logic [SLOTS-1:0]           skip_i,
  input  logic [SLOTS*FIDX_W-1:0]    owner_i,
  input  logic [SLOTS*COST_W-1:0]    cost_i,
  output logic [NUM_FILES*SUM_W-1:0] sum_o
);
  import occ_pkg::*;

  for (genvar f = 0; f < NUM_FILES; f++) begin : g_file
    logic [SUM_W-1:0] acc;
    always_comb begin
      acc = '0;
      for (int s = 0; s < SLOTS; s++) begin
        if (valid_i[s] && !skip_i[s] &&
            charges_file(f, int'(owner_i[s*FIDX_W +: FIDX_W])))
          acc = acc + SUM_W'(cost_i[s*COST_W +: COST_W]);
      end
    end
    assign sum_o[f*SUM_W +: SUM_W] = acc;
  end
endmodule

// File: rtl/occ_file_ctr.sv
module occ_file_ctr #(
  parameter int CNT_W = 6,
  parameter int SUM_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SUM_W-1:0] add_i,
  input  logic [SUM_W-1:0] sub_i,
  output logic [CNT_W-1:0] used_o
);
  localparam int XW = ((CNT_W > SUM_W) ? CNT_W : SUM_W) + 2;
  localparam logic [XW-1:0] MAXV = XW'((1 << CNT_W) - 1);

  logic [XW-1:0]    grow, need, diff;
  logic [CNT_W-1:0] nxt;

  always_comb begin
    grow = XW'(used_o) + XW'(add_i);
    need = XW'(sub_i);
    diff = grow - need;
    if (need > grow)      nxt = '0;
    else if (diff > MAXV) nxt = MAXV[CNT_W-1:0];
    else                  nxt = diff[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) used_o <= '0;
    else     used_o <= nxt;
  end
endmodule

// File: rtl/occ_stall_eval.sv
module occ_stall_eval #(
  parameter int CNT_W = 6,
  parameter int SUM_W = 6
) (
  input  logic [CNT_W-1:0] cap_i,
  input  logic [CNT_W-1:0] used_i,
  input  logic [SUM_W-1:0] req_i,
  output logic             stall_o
);
  localparam int XW = ((CNT_W > SUM_W) ? CNT_W : SUM_W) + 2;

  logic [XW-1:0] capx, reqx, req_eff;

  always_comb begin
    capx    = XW'(cap_i);
    reqx    = XW'(req_i);
    req_eff = (reqx > capx) ? capx : reqx;
    stall_o = (cap_i != '0) && (req_i != '0) && (capx < XW'(used_i) + req_eff);
  end
endmodule

// File: rtl/phys_reg_occupancy.sv
module phys_reg_occupancy #(
  parameter int NUM_FILES = 3,
  parameter int SLOTS     = 4,
  parameter int COST_W    = 3,
  parameter int CNT_W     = 6,
  parameter int FIDX_W    = (NUM_FILES > 1) ? $clog2(NUM_FILES) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_FILES*CNT_W-1:0] cap_i,
  input  logic [SLOTS-1:0]           q_valid,
  input  logic [SLOTS*FIDX_W-1:0]    q_owner,
  input  logic [SLOTS*COST_W-1:0]    q_cost,
  output logic [NUM_FILES-1:0]       q_stall,
  input  logic [SLOTS-1:0]           a_valid,
  input  logic [SLOTS-1:0]           a_skip,
  input  logic [SLOTS*FIDX_W-1:0]    a_owner,
  input  logic [SLOTS*COST_W-1:0]    a_cost,
  input  logic [SLOTS-1:0]           f_valid,
  input  logic [SLOTS-1:0]           f_skip,
  input  logic [SLOTS*FIDX_W-1:0]    f_owner,
  input  logic [SLOTS*COST_W-1:0]    f_cost,
  output logic [NUM_FILES*CNT_W-1:0] used_o
);
  localparam int SUM_W = COST_W + $clog2(SLOTS + 1);

  logic [NUM_FILES*SUM_W-1:0] q_sum, a_sum, f_sum;

  occ_demand #(.NUM_FILES(NUM_FILES), .SLOTS(SLOTS), .FIDX_W(FIDX_W),
               .COST_W(COST_W), .SUM_W(SUM_W)) u_qdem (
    .valid_i(q_valid), .skip_i('0), .owner_i(q_owner), .cost_i(q_cost), .sum_o(q_sum));

  occ_demand #(.NUM_FILES(NUM_FILES), .SLOTS(SLOTS), .FIDX_W(FIDX_W),
               .COST_W(COST_W), .SUM_W(SUM_W)) u_adem (
    .valid_i(a_valid), .skip_i(a_skip), .owner_i(a_owner), .cost_i(a_cost), .sum_o(a_sum));

  occ_demand #(.NUM_FILES(NUM_FILES), .SLOTS(SLOTS), .FIDX_W(FIDX_W),
               .COST_W(COST_W), .SUM_W(SUM_W)) u_fdem (
    .valid_i(f_valid), .skip_i(f_skip), .owner_i(f_owner), .cost_i(f_cost), .sum_o(f_sum));

  for (genvar f = 0; f < NUM_FILES; f++) begin : g_file
    occ_file_ctr #(.CNT_W(CNT_W), .SUM_W(SUM_W)) u_ctr (
      .clk(clk), .rst(rst),
      .add_i(a_sum[f*SUM_W +: SUM_W]),
      .sub_i(f_sum[f*SUM_W +: SUM_W]),
      .used_o(used_o[f*CNT_W +: CNT_W]));

    occ_stall_eval #(.CNT_W(CNT_W), .SUM_W(SUM_W)) u_eval (
      .cap_i(cap_i[f*CNT_W +: CNT_W]),
      .used_i(used_o[f*CNT_W +: CNT_W]),
      .req_i(q_sum[f*SUM_W +: SUM_W]),
      .stall_o(q_stall[f]));
  end
endmodule

// File: rtl/occ_checker.sv
module occ_checker #(
  parameter int NUM_FILES = 3,
  parameter int SLOTS     = 4,
  parameter int COST_W    = 3,
  parameter int CNT_W     = 6,
  parameter int FIDX_W    = 2
) (
  input logic                       clk,
  input logic                       rst,
  input logic [NUM_FILES*CNT_W-1:0] cap_i,
  input logic [SLOTS-1:0]           q_valid,
  input logic [NUM_FILES-1:0]       q_stall,
  input logic [SLOTS-1:0]           a_valid,
  input logic [SLOTS-1:0]           a_skip,
  input logic [SLOTS*COST_W-1:0]    a_cost,
  input logic [SLOTS-1:0]           f_valid,
  input logic [SLOTS-1:0]           f_skip,
  input logic [SLOTS*COST_W-1:0]    f_cost,
  input logic [NUM_FILES*CNT_W-1:0] used_o
);
  int a_tot, f_tot;
  always_comb begin
    a_tot = 0;
    f_tot = 0;
    for (int s = 0; s < SLOTS; s++) begin
      if (a_valid[s] && !a_skip[s]) a_tot = a_tot + int'(a_cost[s*COST_W +: COST_W]);
      if (f_valid[s] && !f_skip[s]) f_tot = f_tot + int'(f_cost[s*COST_W +: COST_W]);
    end
  end

  // R1
  a_r1_reset_clear: assert property (@(posedge clk) $past(rst) |-> (used_o == '0));

  // R5
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!(|(a_valid & ~a_skip)) && !(|(f_valid & ~f_skip))) |=> $stable(used_o));

  // R6
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (rst)
    f_tot <= int'(used_o[0 +: CNT_W]) + a_tot);

  // R10
  a_r10_empty_query: assert property (@(posedge clk) disable iff (rst)
    (q_valid == '0) |-> (q_stall == '0));

  for (genvar f = 0; f < NUM_FILES; f++) begin : g_unb
    // R8
    a_r8_unbounded: assert property (@(posedge clk) disable iff (rst)
      (cap_i[f*CNT_W +: CNT_W] == '0) |-> !q_stall[f]);
  end

  for (genvar f = 1; f < NUM_FILES; f++) begin : g_agg
    // R2: the aggregate file never holds fewer than any single file
    a_r2_aggregate_bound: assert property (@(posedge clk) disable iff (rst)
      used_o[0 +: CNT_W] >= used_o[f*CNT_W +: CNT_W]);
  end
endmodule

bind phys_reg_occupancy occ_checker #(
  .NUM_FILES(NUM_FILES), .SLOTS(SLOTS), .COST_W(COST_W), .CNT_W(CNT_W), .FIDX_W(FIDX_W)
) u_occ_chk (
  .clk(clk), .rst(rst), .cap_i(cap_i), .q_valid(q_valid), .q_stall(q_stall),
  .a_valid(a_valid), .a_skip(a_skip), .a_cost(a_cost),
  .f_valid(f_valid), .f_skip(f_skip), .f_cost(f_cost), .used_o(used_o)
);

// File: tb/phys_reg_occupancy_bench.sv
module phys_reg_occupancy_bench;
  localparam int NF = 3, SL = 4, CW = 3, NW = 6, FW = 2;

  logic clk = 0, rst = 1;
  logic [NF*NW-1:0] cap;
  logic [SL-1:0] qv, av, as_, fv, fs;
  logic [SL*FW-1:0] qo, ao, fo;
  logic [SL*CW-1:0] qc, ac, fc;
  logic [NF-1:0] stall;
  logic [NF*NW-1:0] used;

  int total = 0, bad = 0;
  int exp_u[NF];

  always #5 clk = ~clk;

  phys_reg_occupancy #(.NUM_FILES(NF), .SLOTS(SL), .COST_W(CW), .CNT_W(NW)) u_phys_reg_occupancy (
    .clk(clk), .rst(rst), .cap_i(cap),
    .q_valid(qv), .q_owner(qo), .q_cost(qc), .q_stall(stall),
    .a_valid(av), .a_skip(as_), .a_owner(ao), .a_cost(ac),
    .f_valid(fv), .f_skip(fs), .f_owner(fo), .f_cost(fc), .used_o(used));

  task automatic chk(input string tag, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, expv);
    end
  endtask

  task automatic clear_ops();
    qv = '0; qo = '0; qc = '0;
    av = '0; as_ = '0; ao = '0; ac = '0;
    fv = '0; fs = '0; fo = '0; fc = '0;
  endtask

  task automatic set_cap(input int c0, input int c1, input int c2);
    cap = {NW'(c2), NW'(c1), NW'(c0)};
  endtask

  task automatic put_q(input int s, input int o, input int c);
    qv[s] = 1; qo[s*FW +: FW] = FW'(o); qc[s*CW +: CW] = CW'(c);
  endtask
  task automatic put_a(input int s, input int o, input int c, input bit sk);
    av[s] = 1; as_[s] = sk; ao[s*FW +: FW] = FW'(o); ac[s*CW +: CW] = CW'(c);
  endtask
  task automatic put_f(input int s, input int o, input int c, input bit sk);
    fv[s] = 1; fs[s] = sk; fo[s*FW +: FW] = FW'(o); fc[s*CW +: CW] = CW'(c);
  endtask

  function automatic logic [NF-1:0] model_stall();
    logic [NF-1:0] r = '0;
    for (int f = 0; f < NF; f++) begin
      int req = 0;
      int cp = int'(cap[f*NW +: NW]);
      for (int s = 0; s < SL; s++)
        if (qv[s] && (f == 0 || int'(qo[s*FW +: FW]) == f)) req += int'(qc[s*CW +: CW]);
      if (req > cp) req = cp;
      r[f] = (cp != 0) && (req != 0) && (cp < exp_u[f] + req);
    end
    return r;
  endfunction

  task automatic model_apply();
    for (int s = 0; s < SL; s++) begin
      int o, c;
      if (av[s] && !as_[s]) begin
        o = int'(ao[s*FW +: FW]); c = int'(ac[s*CW +: CW]);
        exp_u[0] += c; if (o != 0) exp_u[o] += c;
      end
      if (fv[s] && !fs[s]) begin
        o = int'(fo[s*FW +: FW]); c = int'(fc[s*CW +: CW]);
        exp_u[0] -= c; if (o != 0) exp_u[o] -= c;
      end
    end
  endtask

  // inputs are stable here; the query is judged before the edge, the counts after it
  task automatic step(input string qtag, input string utag);
    #1;
    chk(qtag, int'(stall), int'(model_stall()));
    @(posedge clk);
    model_apply();
    @(negedge clk);
    for (int f = 0; f < NF; f++) chk(utag, int'(used[f*NW +: NW]), exp_u[f]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd1357);
    for (int f = 0; f < NF; f++) exp_u[f] = 0;
    clear_ops();
    set_cap(40, 20, 12);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset counts", int'(used), 0);

    // R3: owner 0 charges the aggregate only
    put_a(0, 0, 3, 0);
    step("R11 query idle", "R3 owner0 alloc");
    chk("R3 file1 untouched", int'(used[NW +: NW]), 0);

    // R9: oversized request clamped to capacity
    clear_ops(); set_cap(8, 5, 12);
    put_q(0, 1, 7);
    #1; chk("R9 clamp to capacity", int'(stall), 3'b001);
    chk("R9 model agrees", int'(stall), int'(model_stall()));

    // R2: owned allocations hit both the owner and the aggregate
    clear_ops(); set_cap(40, 20, 12);
    put_a(0, 1, 4, 0); put_a(2, 2, 2, 0);
    step("R7 query", "R2 owned alloc");
    chk("R2 aggregate", int'(used[0 +: NW]), 9);

    // R5: skipped and invalid slots change nothing
    clear_ops();
    put_a(1, 1, 5, 1); put_f(0, 2, 2, 1);
    ac[3*CW +: CW] = 3'd6; ao[3*FW +: FW] = 2'd1;
    fc[2*CW +: CW] = 3'd2; fo[2*FW +: FW] = 2'd1;
    step("R7 query", "R5 skip no effect");
    chk("R5 file1 held", int'(used[NW +: NW]), 4);

    // R6: simultaneous allocate and free in the same file
    clear_ops();
    put_a(0, 1, 3, 0); put_f(1, 1, 4, 0);
    put_q(0, 1, 2);
    step("R7 query with alloc/free", "R6 net update");
    chk("R6 file1 net", int'(used[NW +: NW]), 3);
    chk("R6 file0 net", int'(used[0 +: NW]), 8);

    // R4: frees subtract from owner and aggregate
    clear_ops();
    put_f(0, 0, 3, 0); put_f(3, 2, 2, 0);
    step("R7 query", "R4 free");
    chk("R4 file2 empty", int'(used[2*NW +: NW]), 0);

    // R8: zero capacity is unbounded
    clear_ops(); set_cap(40, 0, 12);
    for (int s = 0; s < SL; s++) put_q(s, 1, 7);
    #1; chk("R8 unbounded file", int'(stall), 3'b000);
    set_cap(40, 4, 12);
    #1; chk("R7 bounded file stalls", int'(stall), 3'b010);

    // R10: over-full file with no demand stays clear
    clear_ops(); set_cap(40, 20, 2);
    put_a(0, 2, 3, 0);
    step("R7 query", "R10 setup");
    chk("R10 over capacity count", int'(used[2*NW +: NW]), 3);
    put_q(1, 1, 1);
    #1; chk("R10 zero demand no stall", int'(stall), 3'b000);
    clear_ops();
    #1; chk("R10 empty query", int'(stall), 3'b000);

    // random phase
    for (int it = 0; it < 500; it++) begin
      int room, own0;
      int avl[NF];
      if (it % 50 == 0)
        set_cap((($urandom % 4) == 0) ? 0 : int'($urandom_range(60, 10)),
                (($urandom % 4) == 0) ? 0 : int'($urandom_range(30, 2)),
                (($urandom % 4) == 0) ? 0 : int'($urandom_range(30, 2)));
      clear_ops();
      room = 60 - exp_u[0];
      avl[1] = exp_u[1]; avl[2] = exp_u[2];
      own0 = exp_u[0] - exp_u[1] - exp_u[2];
      for (int s = 0; s < SL; s++) begin
        int o, c;
        bit sk;
        if ($urandom % 2 == 1) put_q(s, int'($urandom_range(2, 0)), int'($urandom_range(7, 0)));
        o = int'($urandom_range(2, 0)); c = int'($urandom_range(7, 0)); sk = ($urandom % 5) == 0;
        if ($urandom % 2 == 1 && (sk || c <= room)) begin
          put_a(s, o, c, sk);
          if (!sk) room -= c;
        end
        o = int'($urandom_range(2, 0)); c = int'($urandom_range(7, 0)); sk = ($urandom % 5) == 0;
        if ($urandom % 2 == 1) begin
          if (sk) put_f(s, o, c, sk);
          else if (o == 0 && c <= own0) begin put_f(s, o, c, sk); own0 -= c; end
          else if (o != 0 && c <= avl[o]) begin put_f(s, o, c, sk); avl[o] -= c; end
        end
      end
      step("R7 random query", "R6 random update");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule